// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block makes the serial clock of an SPI master from the module clock. It offers two ways to divide. The first uses a 4-bit exponent and divides by a power of two. The second uses an 8-bit value and divides by an even integer. A one-bit mode input chooses between them. In both modes the fastest serial clock is half the module clock.

While no transfer is running, the clock pin rests at the idle polarity and the block emits nothing. Once the transfer-active input rises, the clock toggles at every half-period boundary. Each toggle comes with a one-cycle strobe, either launch or sample, for the shift engine next to it. The clock phase input sets which of the two strobes goes with the leading edge.

The divider settings and the polarity and phase inputs are captured only while the block is idle. A transfer therefore keeps one constant rate and one constant polarity from start to finish.

Top module: `spi_sclk_divider`

## Requirements
- R1: While reset is high, sclk, launch_stb and sample_stb are all 0, whatever value the cpol input has.
- R2: While xfer_active is 0, sclk takes the value the cpol input had at the previous clock edge, and neither strobe is asserted.
- R3: With div_mode = 0 (power-of-two scheme), one half-period of sclk lasts 2^pow_exp module cycles, so sclk is the module clock divided by 2^(pow_exp+1). lin_div has no effect in this mode.
- R4: With div_mode = 1 (linear scheme), one half-period lasts lin_div+1 module cycles, so the ratio is 2*(lin_div+1). pow_exp has no effect in this mode.
- R5: The smallest ratio is 2. pow_exp = 0 in mode 0 and lin_div = 0 in mode 1 both make sclk toggle on every module clock edge.
- R6: Say h is the half-period length. The first sclk toggle happens on the h-th rising clock edge that sees xfer_active high, and each later toggle follows h edges after the one before.
- R7: Every sclk toggle comes with exactly one strobe, asserted in the same cycle that sclk changes. With cpha = 0, the leading edge (the one leaving the idle level) carries sample_stb and the trailing edge carries launch_stb. With cpha = 1 the two are swapped.
- R8: Changes to div_mode, pow_exp, lin_div, cpol or cpha while xfer_active is 1 do not affect the rate, the levels or the strobe order until the block is idle again.
- R9: launch_stb and sample_stb are never high together, and neither one is asserted in a cycle without an sclk toggle.
- R10: One cycle after xfer_active falls, sclk is back at the idle level. The next transfer starts from that level with a full half-period, so no short pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_active | input | 1 | High while a transfer is in progress |
| div_mode | input | 1 | 0 = power-of-two scheme, 1 = linear even scheme |
| pow_exp | input | EXP_W | Exponent for the power-of-two scheme |
| lin_div | input | LIN_W | Value for the linear scheme |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | 0 = sample on the leading edge, 1 = launch on the leading edge |
| sclk | output | 1 | Serial clock level |
| launch_stb | output | 1 | One-cycle strobe on a launch edge |
| sample_stb | output | 1 | One-cycle strobe on a sample edge |

## Verification
The bench builds the block with the default widths: a 4-bit exponent, an 8-bit linear field and a 16-bit half-period counter. The test vectors use half-periods from 1 up to 32 cycles. This covers the ratio-2 case in both schemes, the case where the unused field holds a non-zero value, and all four combinations of polarity and phase. The long half-periods that only the upper exponent values produce are left out, because their behaviour comes from the same counter comparison.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  localparam logic DIV_POW2   = 1'b0;
  localparam logic DIV_LINEAR = 1'b1;

  // counter width able to hold the largest half-period of either scheme
  function automatic int half_width(input int exp_w, input int lin_w);
    int pw;
    int lw;
    pw = 1 << exp_w;
    lw = lin_w + 1;
    return (pw > lw) ? pw : lw;
  endfunction
endpackage

// File: rtl/spi_div_cfg.sv
module spi_div_cfg
  import spi_div_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter int LIN_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic             mode_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [LIN_W-1:0] lin_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  output logic [CNT_W-1:0] half_o,
  output logic             cpol_o,
  output logic             cpha_o
);
  logic [CNT_W-1:0] half_q;
  logic             cpol_q;
  logic             cpha_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= CNT_W'(1);
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
    end else if (!active_i) begin
      if (mode_i == DIV_LINEAR)
        half_q <= CNT_W'(lin_i) + CNT_W'(1);
      else
        half_q <= CNT_W'(1) << exp_i;
      cpol_q <= cpol_i;
      cpha_q <= cpha_i;
    end
  end

  assign half_o = half_q;
  assign cpol_o = cpol_q;
  assign cpha_o = cpha_q;

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (active_i && $past(active_i)) |-> ($stable(half_q) && $stable(cpol_q) && $stable(cpha_q)));

  // R5
  half_nonzero_chk: assert property (@(posedge clk) disable iff (rst) half_q != '0);
endmodule

// File: rtl/spi_div_timer.sv
module spi_div_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             edge_o
);
  logic [CNT_W-1:0] cnt_q;

  assign edge_o = active_i && (cnt_q == half_i - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !active_i)
      cnt_q <= '0;
    else if (edge_o)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + CNT_W'(1);
  end

  // R6
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst) cnt_q < half_i);

  // R10
  idle_cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> (cnt_q == '0));
endmodule

// File: rtl/spi_div_edge.sv
module spi_div_edge (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic edge_i,
  input  logic cpol_raw_i,
  input  logic cpol_i,
  input  logic cpha_i,
  output logic sclk_o,
  output logic launch_o,
  output logic sample_o
);
  logic sclk_q;
  logic launch_q;
  logic sample_q;
  logic leading;

  // leaving the idle level means a leading edge
  assign leading = (sclk_q == cpol_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      launch_q <= 1'b0;
      sample_q <= 1'b0;
    end else if (!active_i) begin
      sclk_q   <= cpol_raw_i;
      launch_q <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      launch_q <= 1'b0;
      sample_q <= 1'b0;
      if (edge_i) begin
        sclk_q <= ~sclk_q;
        if (leading != cpha_i) sample_q <= 1'b1;
        else                   launch_q <= 1'b1;
      end
    end
  end

  assign sclk_o   = sclk_q;
  assign launch_o = launch_q;
  assign sample_o = sample_q;

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> ((sclk_q == $past(cpol_raw_i)) && !launch_q && !sample_q));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(launch_q && sample_q));

  // R9
  strobe_needs_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (launch_q || sample_q) |-> !$stable(sclk_q));

  // R7
  toggle_has_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(active_i) && !$stable(sclk_q)) |-> (launch_q || sample_q));

  // R7
  sample_order_chk: assert property (@(posedge clk) disable iff (rst)
    sample_q |-> ((sclk_q != cpol_i) != cpha_i));
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import spi_div_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter int LIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_active,
  input  logic             div_mode,
  input  logic [EXP_W-1:0] pow_exp,
  input  logic [LIN_W-1:0] lin_div,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sclk,
  output logic             launch_stb,
  output logic             sample_stb
);
  localparam int CNT_W = half_width(EXP_W, LIN_W);

  logic [CNT_W-1:0] half_len;
  logic             cpol_lat;
  logic             cpha_lat;
  logic             edge_now;

  spi_div_cfg #(.EXP_W(EXP_W), .LIN_W(LIN_W), .CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .active_i (xfer_active),
    .mode_i   (div_mode),
    .exp_i    (pow_exp),
    .lin_i    (lin_div),
    .cpol_i   (cpol),
    .cpha_i   (cpha),
    .half_o   (half_len),
    .cpol_o   (cpol_lat),
    .cpha_o   (cpha_lat)
  );

  spi_div_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .active_i (xfer_active),
    .half_i   (half_len),
    .edge_o   (edge_now)
  );

  spi_div_edge u_edge (
    .clk        (clk),
    .rst        (rst),
    .active_i   (xfer_active),
    .edge_i     (edge_now),
    .cpol_raw_i (cpol),
    .cpol_i     (cpol_lat),
    .cpha_i     (cpha_lat),
    .sclk_o     (sclk),
    .launch_o   (launch_stb),
    .sample_o   (sample_stb)
  );
endmodule

// File: tb/test_spi_sclk_divider.sv
module test_spi_sclk_divider;
  localparam int CLK_P = 10;
  localparam int NV = 8;

  localparam int V_SEL [NV]  = '{0, 1, 0, 1, 0, 1, 0, 1};
  localparam int V_EXP [NV]  = '{0, 7, 2, 0, 3, 0, 5, 5};
  localparam int V_LIN [NV]  = '{40, 0, 0, 3, 0, 6, 9, 9};
  localparam int V_POL [NV]  = '{0, 1, 0, 1, 1, 0, 0, 1};
  localparam int V_PHA [NV]  = '{0, 0, 1, 1, 0, 1, 0, 0};
  localparam int V_HALF [NV] = '{1, 1, 4, 4, 8, 7, 32, 10};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xfer_active = 1'b0;
  logic div_mode = 1'b0;
  logic [3:0] pow_exp = '0;
  logic [7:0] lin_div = '0;
  logic cpol = 1'b0;
  logic cpha = 1'b0;
  logic sclk, launch_stb, sample_stb;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_sclk_divider i_spi_sclk_divider (
    .clk(clk), .rst(rst), .xfer_active(xfer_active), .div_mode(div_mode),
    .pow_exp(pow_exp), .lin_div(lin_div), .cpol(cpol), .cpha(cpha),
    .sclk(sclk), .launch_stb(launch_stb), .sample_stb(sample_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int sel, input int ex, input int ln, input int pol,
                         input int pha, input int h);
    logic prev;
    int j;
    string tag;
    tag = (h == 1) ? "R5" : ((sel == 1) ? "R4" : "R3");
    @(negedge clk);
    xfer_active = 1'b0;
    div_mode = sel[0]; pow_exp = ex[3:0]; lin_div = ln[7:0];
    cpol = pol[0]; cpha = pha[0];
    repeat (3) @(negedge clk);
    chk(sclk == pol[0] && !launch_stb && !sample_stb, "R2 idle", int'(sclk), pol);
    xfer_active = 1'b1;
    prev = sclk;
    j = 0;
    for (int k = 1; k <= 4*h + 4; k++) begin
      @(negedge clk);
      if (sclk != prev) begin
        bit lead;
        bit exp_sample;
        lead = (prev == pol[0]);
        exp_sample = (lead != pha[0]);
        chk(k == h*(j+1), (j == 0) ? "R6 first toggle" : tag, k, h*(j+1));
        chk(sample_stb == exp_sample && launch_stb == !exp_sample, "R7 strobe kind",
            int'(sample_stb), int'(exp_sample));
        prev = sclk;
        j++;
        if (j == 4) break;
      end else begin
        chk(!launch_stb && !sample_stb, "R9 stray strobe", int'(launch_stb | sample_stb), 0);
      end
    end
    chk(j == 4, tag, j, 4);
    xfer_active = 1'b0;
    @(negedge clk);
    chk(sclk == pol[0] && !launch_stb && !sample_stb, "R10 return idle", int'(sclk), pol);
  endtask

  initial begin
    #(CLK_P * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    // R1: reset holds outputs low even with cpol = 1
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0 && !launch_stb && !sample_stb, "R1 reset", int'(sclk), 0);
    @(negedge clk);
    rst = 1'b0;
    cpol = 1'b0;

    for (int v = 0; v < NV; v++)
      run_vec(V_SEL[v], V_EXP[v], V_LIN[v], V_POL[v], V_PHA[v], V_HALF[v]);

    // R8: change configuration mid-transfer
    @(negedge clk);
    div_mode = 1'b1; lin_div = 8'd1; pow_exp = 4'd0; cpol = 1'b0; cpha = 1'b0;
    repeat (2) @(negedge clk);
    xfer_active = 1'b1;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b1 && sample_stb, "R8 first toggle", int'(sclk), 1);
    div_mode = 1'b0; pow_exp = 4'd4; cpol = 1'b1; cpha = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1 && !launch_stb && !sample_stb, "R8 hold", int'(sclk), 1);
    @(negedge clk);
    chk(sclk == 1'b0 && launch_stb && !sample_stb, "R8 rate and phase kept", int'(sclk), 0);
    @(negedge clk);
    chk(sclk == 1'b0, "R8 level kept", int'(sclk), 0);
    @(negedge clk);
    chk(sclk == 1'b1 && sample_stb, "R8 third toggle", int'(sclk), 1);

    // R10: drop mid half-period with sclk high, idle is now 1 from the new cpol
    xfer_active = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b1 && !launch_stb && !sample_stb, "R10 idle after drop", int'(sclk), 1);
    div_mode = 1'b1; lin_div = 8'd1; cpol = 1'b0; cpha = 1'b0;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b0, "R2 idle follows cpol", int'(sclk), 0);
    xfer_active = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b0 && !sample_stb, "R10 no runt", int'(sclk), 0);
    @(negedge clk);
    chk(sclk == 1'b1 && sample_stb, "R10 full first half", int'(sclk), 1);
    xfer_active = 1'b0;
    k = 0;
    @(negedge clk);
    chk(sclk == 1'b0 && k == 0, "R10 final idle", int'(sclk), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule